// File: doc/BRIEF.md
# DMA Descriptor Fetch Sequencer

This block loads the parameter set of one DMA channel from descriptors held in memory. Software programs three values through a small write port: a next-descriptor pointer, a current-descriptor pointer and a configuration word. The configuration word carries a flow field, in bits 14:12, and a descriptor-size field, in bits 11:8. When the flow field names a descriptor mode, the sequencer reads 16-bit words from memory. It holds each request until memory returns valid data, and it writes each returned word into the channel parameter register that matches the word's position in the descriptor.

Three descriptor modes exist. Two are chained lists: in one the next pointer is a single 16-bit word, and in the other it spans two words. The third is a contiguous array in which descriptors carry no pointer and follow one another directly in memory. The size field states how many words the next fetch reads. A fetched configuration word does not take effect until the whole descriptor has been read. The transfer engine sees a one-cycle completion pulse after each fetch, and it can request the next fetch by pulsing a request input.

Top module: `dma_desc_fetch`

## Requirements
- R1: Flow values 4 (array), 6 (list with 16-bit pointer) and 7 (list with 32-bit pointer) are descriptor modes. Writing a configuration word whose flow field holds any other value stores the word and issues no memory read.
- R2: A configuration write with a descriptor flow starts a fetch. In the two list modes the current pointer is first loaded from the next pointer. In array mode the current pointer is used exactly as software last wrote it or as the previous fetch left it.
- R3: While a fetch is running, mem_req stays high and mem_addr stays stable until mem_valid is seen. Each accepted word advances the current pointer, and with it mem_addr, by 2.
- R4: Words are read in the order pointer low, pointer high, start low, start high, configuration, X count, X modify, Y count, Y modify. The 16-bit-pointer list omits pointer high, and array mode omits both pointer words.
- R5: A fetch reads exactly the number of words given by the size field. When the size field is larger than the number of slots the mode has (9, 8 or 7), the fetch reads all of the mode's slots.
- R6: In the 16-bit-pointer list mode a fetch loads only bits 15:0 of the next pointer. Bits 31:16 keep their value.
- R7: The configuration output does not change while a fetch is running. A fetched configuration word appears on the output only when the fetch completes.
- R8: fetch_done is high for exactly one cycle: the cycle after the last word is accepted. busy is low in that same cycle.
- R9: A fetch_req pulse while the block is idle starts a fetch using the stored configuration. List modes start from the next pointer, and array mode continues at the address directly after the previous descriptor.
- R10: A descriptor flow with a size field of 0 sets size_err and issues no read. While size_err is set, fetch_req is ignored. The next configuration write clears size_err.
- R11: Software writes arriving while busy is high are ignored.
- R12: After reset all parameter outputs are zero, and busy, mem_req, fetch_done and size_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Write target: 0 next pointer, 1 current pointer, 2 configuration |
| sw_data | input | 32 | Write data (configuration uses bits 15:0) |
| fetch_req | input | 1 | Transfer engine asks for the next descriptor |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_valid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Fetch in progress |
| fetch_done | output | 1 | One-cycle completion pulse |
| size_err | output | 1 | Sticky zero-size error |
| next_ptr | output | 32 | Next-descriptor pointer |
| curr_ptr | output | 32 | Current-descriptor pointer |
| start_addr | output | 32 | Start address parameter |
| cfg_word | output | 16 | Active configuration word |
| x_count | output | 16 | X count parameter |
| x_modify | output | 16 | X modify parameter |
| y_count | output | 16 | Y count parameter |
| y_modify | output | 16 | Y modify parameter |

## Verification
Each of the three descriptor flows is swept through every size code from 0 to 15. Because the memory model returns a different value for every address, each parameter register shows exactly which address fed it, so a mistake in word order, slot skipping or clamping produces the wrong value. Memory stalls on every third cycle to exercise the request hold. Short chained fetches check the difference between the small and large pointer reloads and the continuation in array mode. Non-descriptor flows, zero sizes and writes made while busy are checked as cases that must leave no trace on memory or on the registers.

// File: rtl/dmadf_pkg.sv
package dmadf_pkg;

  localparam int FLOW_LSB = 12;
  localparam int SIZE_LSB = 8;

  localparam logic [2:0] FLOW_ARRAY  = 3'd4;
  localparam logic [2:0] FLOW_LIST_S = 3'd6;
  localparam logic [2:0] FLOW_LIST_L = 3'd7;

  typedef enum logic [3:0] {
    SL_NPL, SL_NPH, SL_SAL, SL_SAH, SL_CFG, SL_XC, SL_XM, SL_YC, SL_YM
  } slot_e;

  function automatic logic is_desc(input logic [2:0] flow);
    return (flow == FLOW_ARRAY) || (flow == FLOW_LIST_S) || (flow == FLOW_LIST_L);
  endfunction

  function automatic logic is_list(input logic [2:0] flow);
    return (flow == FLOW_LIST_S) || (flow == FLOW_LIST_L);
  endfunction

  function automatic logic [3:0] slot_total(input logic [2:0] flow);
    if (flow == FLOW_LIST_L)      return 4'd9;
    else if (flow == FLOW_LIST_S) return 4'd8;
    else                          return 4'd7;
  endfunction

  function automatic slot_e slot_at(input logic [2:0] flow, input logic [3:0] idx);
    logic [3:0] pos;
    if (flow == FLOW_LIST_L)      pos = idx;
    else if (flow == FLOW_LIST_S) pos = (idx == 4'd0) ? 4'd0 : idx + 4'd1;
    else                          pos = idx + 4'd2;
    return slot_e'(pos);
  endfunction

endpackage

// File: rtl/dmadf_ctrl.sv
module dmadf_ctrl
  import dmadf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] wr_flow,
  input  logic [3:0] wr_size,
  input  logic [2:0] cur_flow,
  input  logic [3:0] cur_size,
  input  logic       fetch_req,
  input  logic       mem_valid,
  output logic       busy,
  output logic       word_we,
  output slot_e      slot,
  output logic       last_word,
  output logic       load_list_ptr,
  output logic       fetch_done,
  output logic       size_err
);

  logic       busy_q, busy_d;
  logic [2:0] flow_q, flow_d;
  logic [3:0] words_q, words_d;
  logic [3:0] idx_q, idx_d;
  logic       done_q, done_d;
  logic       err_q, err_d;

  logic       trig_cfg, trig_req, trig, start, err_hit;
  logic [2:0] sel_flow;
  logic [3:0] sel_size, sel_total;

  always_comb begin
    trig_cfg  = cfg_wr && is_desc(wr_flow);
    trig_req  = fetch_req && !busy_q && !err_q && !cfg_wr && is_desc(cur_flow);
    trig      = trig_cfg || trig_req;
    sel_flow  = trig_cfg ? wr_flow : cur_flow;
    sel_size  = trig_cfg ? wr_size : cur_size;
    sel_total = slot_total(sel_flow);
    start     = trig && (sel_size != 4'd0);
    err_hit   = trig && (sel_size == 4'd0);

    word_we       = busy_q && mem_valid;
    last_word     = word_we && (idx_q == words_q - 4'd1);
    slot          = slot_at(flow_q, idx_q);
    load_list_ptr = start && is_list(sel_flow);

    busy_d  = busy_q;
    flow_d  = flow_q;
    words_d = words_q;
    idx_d   = idx_q;
    if (start) begin
      busy_d  = 1'b1;
      flow_d  = sel_flow;
      words_d = (sel_size > sel_total) ? sel_total : sel_size;
      idx_d   = 4'd0;
    end else if (word_we) begin
      idx_d = idx_q + 4'd1;
      if (last_word) busy_d = 1'b0;
    end

    done_d = last_word;

    err_d = err_q;
    if (err_hit)     err_d = 1'b1;
    else if (cfg_wr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      flow_q  <= 3'd0;
      words_q <= 4'd0;
      idx_q   <= 4'd0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      flow_q  <= flow_d;
      words_q <= words_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy       = busy_q;
  assign fetch_done = done_q;
  assign size_err   = err_q;

  // R10: an error state never coexists with an active fetch
  assert_err_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy_q);

  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: a fetch ending always produces the pulse
  assert_done_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

endmodule

// File: rtl/dmadf_params.sv
module dmadf_params
  import dmadf_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int ADDR_W = 2 * WORD_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [ADDR_W-1:0] sw_data,
  input  logic              load_list_ptr,
  input  logic              word_we,
  input  slot_e             slot,
  input  logic              last_word,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] curr_ptr,
  output logic [ADDR_W-1:0] start_addr,
  output logic [WORD_W-1:0] cfg_word,
  output logic [WORD_W-1:0] x_count,
  output logic [WORD_W-1:0] x_modify,
  output logic [WORD_W-1:0] y_count,
  output logic [WORD_W-1:0] y_modify
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0] np_q, np_d, cp_q, cp_d, sa_q, sa_d;
  logic [WORD_W-1:0] cfg_q, cfg_d, xc_q, xc_d, xm_q, xm_d, yc_q, yc_d, ym_q, ym_d;
  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic              pend_q, pend_d;
  logic              wr_np, wr_cp, wr_cfg;

  always_comb begin
    wr_np  = sw_we && (sw_sel == 2'd0);
    wr_cp  = sw_we && (sw_sel == 2'd1);
    wr_cfg = sw_we && (sw_sel == 2'd2);

    np_d = np_q; cp_d = cp_q; sa_d = sa_q;
    cfg_d = cfg_q; xc_d = xc_q; xm_d = xm_q; yc_d = yc_q; ym_d = ym_q;
    shadow_d = shadow_q; pend_d = pend_q;

    if (wr_np) np_d = sw_data;

    if (wr_cp)              cp_d = sw_data;
    else if (load_list_ptr) cp_d = np_q;
    else if (word_we)       cp_d = cp_q + STEP;

    if (wr_cfg) begin
      cfg_d  = sw_data[WORD_W-1:0];
      pend_d = 1'b0;
    end

    if (word_we) begin
      case (slot)
        SL_NPL: np_d[WORD_W-1:0]      = rdata;
        SL_NPH: np_d[ADDR_W-1:WORD_W] = rdata;
        SL_SAL: sa_d[WORD_W-1:0]      = rdata;
        SL_SAH: sa_d[ADDR_W-1:WORD_W] = rdata;
        SL_CFG: begin shadow_d = rdata; pend_d = 1'b1; end
        SL_XC:  xc_d = rdata;
        SL_XM:  xm_d = rdata;
        SL_YC:  yc_d = rdata;
        default: ym_d = rdata;
      endcase
      if (last_word) begin
        pend_d = 1'b0;
        if (slot == SL_CFG) cfg_d = rdata;
        else if (pend_q)    cfg_d = shadow_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      np_q <= '0; cp_q <= '0; sa_q <= '0;
      cfg_q <= '0; xc_q <= '0; xm_q <= '0; yc_q <= '0; ym_q <= '0;
      shadow_q <= '0; pend_q <= 1'b0;
    end else begin
      np_q <= np_d; cp_q <= cp_d; sa_q <= sa_d;
      cfg_q <= cfg_d; xc_q <= xc_d; xm_q <= xm_d; yc_q <= yc_d; ym_q <= ym_d;
      shadow_q <= shadow_d; pend_q <= pend_d;
    end
  end

  assign next_ptr   = np_q;
  assign curr_ptr   = cp_q;
  assign start_addr = sa_q;
  assign cfg_word   = cfg_q;
  assign x_count    = xc_q;
  assign x_modify   = xm_q;
  assign y_count    = yc_q;
  assign y_modify   = ym_q;

  // R6: loading the low pointer word leaves the upper half intact
  assert_upper_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_we && slot == SL_NPL) |=> np_q[ADDR_W-1:WORD_W] == $past(np_q[ADDR_W-1:WORD_W]));

  // R3: each accepted word moves the read address by one word
  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_we |=> cp_q == $past(cp_q) + STEP);

endmodule

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch
  import dmadf_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int ADDR_W = 2 * WORD_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [ADDR_W-1:0] sw_data,
  input  logic              fetch_req,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              fetch_done,
  output logic              size_err,
  output logic [ADDR_W-1:0] next_ptr,
  output logic [ADDR_W-1:0] curr_ptr,
  output logic [ADDR_W-1:0] start_addr,
  output logic [WORD_W-1:0] cfg_word,
  output logic [WORD_W-1:0] x_count,
  output logic [WORD_W-1:0] x_modify,
  output logic [WORD_W-1:0] y_count,
  output logic [WORD_W-1:0] y_modify
);

  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic  sw_we_ok, cfg_wr, word_we, last_word, load_list_ptr, busy_w;
  slot_e slot;

  assign sw_we_ok = sw_we && !busy_w;
  assign cfg_wr   = sw_we_ok && (sw_sel == 2'd2);

  dmadf_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_ns),
    .cfg_wr        (cfg_wr),
    .wr_flow       (sw_data[FLOW_LSB+2:FLOW_LSB]),
    .wr_size       (sw_data[SIZE_LSB+3:SIZE_LSB]),
    .cur_flow      (cfg_word[FLOW_LSB+2:FLOW_LSB]),
    .cur_size      (cfg_word[SIZE_LSB+3:SIZE_LSB]),
    .fetch_req     (fetch_req),
    .mem_valid     (mem_valid),
    .busy          (busy_w),
    .word_we       (word_we),
    .slot          (slot),
    .last_word     (last_word),
    .load_list_ptr (load_list_ptr),
    .fetch_done    (fetch_done),
    .size_err      (size_err)
  );

  dmadf_params #(.WORD_W(WORD_W)) u_params (
    .clk           (clk),
    .rst_n         (rst_ns),
    .sw_we         (sw_we_ok),
    .sw_sel        (sw_sel),
    .sw_data       (sw_data),
    .load_list_ptr (load_list_ptr),
    .word_we       (word_we),
    .slot          (slot),
    .last_word     (last_word),
    .rdata         (mem_rdata),
    .next_ptr      (next_ptr),
    .curr_ptr      (curr_ptr),
    .start_addr    (start_addr),
    .cfg_word      (cfg_word),
    .x_count       (x_count),
    .x_modify      (x_modify),
    .y_count       (y_count),
    .y_modify      (y_modify)
  );

  assign busy     = busy_w;
  assign mem_req  = busy_w;
  assign mem_addr = curr_ptr;

  // R3: an unanswered request is held with the same address
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R7: the active configuration is frozen until the final word
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && !last_word) |=> $stable(cfg_word));

  // R10: no memory traffic while the size error stands
  assert_err_no_req_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    size_err |-> !mem_req);

  // R11: a write arriving during a fetch does not touch the next pointer
  // unless the fetch itself loads a pointer word
  assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (busy_w && sw_we && sw_sel == 2'd0 && !word_we) |=> $stable(next_ptr));

endmodule

// File: tb/dma_desc_fetch_bench.sv
module dma_desc_fetch_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_we;
  logic [1:0]  sw_sel;
  logic [31:0] sw_data;
  logic        fetch_req;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [15:0] mem_rdata;
  logic        busy, fetch_done, size_err;
  logic [31:0] next_ptr, curr_ptr, start_addr;
  logic [15:0] cfg_word, x_count, x_modify, y_count, y_modify;

  always #5 clk = ~clk;

  dma_desc_fetch u_dma_desc_fetch (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel), .sw_data(sw_data),
    .fetch_req(fetch_req), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .busy(busy),
    .fetch_done(fetch_done), .size_err(size_err), .next_ptr(next_ptr),
    .curr_ptr(curr_ptr), .start_addr(start_addr), .cfg_word(cfg_word),
    .x_count(x_count), .x_modify(x_modify), .y_count(y_count), .y_modify(y_modify)
  );

  int errors = 0;
  int checks = 0;
  int accepted = 0;
  bit req_seen = 0;
  bit finished = 0;

  logic [31:0] e_np, e_cp, e_sa;
  logic [15:0] e_cfg, e_xc, e_xm, e_yc, e_ym;
  int          e_n;

  function automatic logic [15:0] memw(input logic [31:0] a);
    logic [15:0] t;
    t = a[15:0] * 16'd7;
    return t ^ a[31:16] ^ 16'h3C5A;
  endfunction

  // memory model: stalls every third cycle
  initial begin
    int stall;
    stall = 0;
    mem_valid = 1'b0;
    mem_rdata = 16'h0;
    forever begin
      @(negedge clk);
      stall = (stall + 1) % 3;
      if (mem_req) req_seen = 1;
      mem_valid = mem_req && (stall != 1);
      mem_rdata = memw(mem_addr);
      if (mem_valid) accepted++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  // expected outcome of one fetch, derived from R2, R4, R5, R6, R7
  task automatic model_fetch(input logic [2:0] fl, input logic [3:0] sz);
    int tot, n, pos;
    logic [31:0] base;
    logic [15:0] v, sh;
    bit pend;
    tot = (fl == 3'd7) ? 9 : (fl == 3'd6) ? 8 : 7;
    n = (int'(sz) > tot) ? tot : int'(sz);
    if (fl != 3'd4) e_cp = e_np;
    base = e_cp;
    pend = 0;
    sh = 16'h0;
    for (int k = 0; k < n; k++) begin
      pos = (fl == 3'd7) ? k : (fl == 3'd6) ? ((k == 0) ? 0 : k + 1) : k + 2;
      v = memw(base + 32'(2 * k));
      case (pos)
        0: e_np[15:0]  = v;
        1: e_np[31:16] = v;
        2: e_sa[15:0]  = v;
        3: e_sa[31:16] = v;
        4: begin sh = v; pend = 1; end
        5: e_xc = v;
        6: e_xm = v;
        7: e_yc = v;
        default: e_ym = v;
      endcase
    end
    e_cp = base + 32'(2 * n);
    if (pend) e_cfg = sh;
    e_n = n;
  endtask

  task automatic wait_done(input string tag);
    bit seen;
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (fetch_done) begin seen = 1; break; end
    end
    chk({tag, " R8 done seen"}, 32'(seen), 32'd1);
    chk({tag, " R8 busy low at done"}, 32'(busy), 32'd0);
  endtask

  task automatic verify_all(input string tag);
    chk({tag, " R6 next_ptr"}, next_ptr, e_np);
    chk({tag, " R2 curr_ptr"}, curr_ptr, e_cp);
    chk({tag, " R4 start_addr"}, start_addr, e_sa);
    chk({tag, " R7 cfg_word"}, 32'(cfg_word), 32'(e_cfg));
    chk({tag, " R4 x_count"}, 32'(x_count), 32'(e_xc));
    chk({tag, " R4 x_modify"}, 32'(x_modify), 32'(e_xm));
    chk({tag, " R4 y_count"}, 32'(y_count), 32'(e_yc));
    chk({tag, " R4 y_modify"}, 32'(y_modify), 32'(e_ym));
    chk({tag, " R5 words read"}, 32'(accepted), 32'(e_n));
    chk({tag, " R10 no error"}, 32'(size_err), 32'd0);
    @(negedge clk);
    chk({tag, " R8 single pulse"}, 32'(fetch_done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] flows [3];
    logic [15:0] cw;
    flows[0] = 3'd4; flows[1] = 3'd6; flows[2] = 3'd7;
    rst_n = 1'b0; sw_we = 1'b0; sw_sel = 2'd3; sw_data = 32'h0; fetch_req = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", 32'(busy), 32'd0);
    chk("R12 mem_req", 32'(mem_req), 32'd0);
    chk("R12 done", 32'(fetch_done), 32'd0);
    chk("R12 err", 32'(size_err), 32'd0);
    chk("R12 next_ptr", next_ptr, 32'h0);
    chk("R12 cfg", 32'(cfg_word), 32'h0);
    chk("R12 start", start_addr, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    e_np = 0; e_cp = 0; e_sa = 0; e_cfg = 0; e_xc = 0; e_xm = 0; e_yc = 0; e_ym = 0;

    // R1 non-descriptor flows issue no reads
    for (int f = 0; f < 8; f++) begin
      if (f == 4 || f == 6 || f == 7) continue;
      req_seen = 0;
      cw = {1'b0, 3'(f), 4'd5, 8'h3C};
      sw_write(2'd2, {16'h0, cw});
      e_cfg = cw;
      repeat (4) @(negedge clk);
      chk("R1 no read for flow", 32'(req_seen), 32'd0);
      chk("R1 cfg stored", 32'(cfg_word), 32'(cw));
    end

    // sweep every descriptor flow and size code
    for (int fi = 0; fi < 3; fi++) begin
      for (int sz = 0; sz < 16; sz++) begin
        e_np = 32'h0012_4000 + 32'(fi * 32'h100 + sz * 32'h20);
        e_cp = 32'h0034_8000 + 32'(fi * 32'h200 + sz * 32'h40);
        sw_write(2'd0, e_np);
        sw_write(2'd1, e_cp);
        cw = {1'b0, flows[fi], 4'(sz), 8'(sz * 3)};
        accepted = 0;
        req_seen = 0;
        sw_write(2'd2, {16'h0, cw});
        e_cfg = cw;
        if (sz == 0) begin
          repeat (3) @(negedge clk);
          chk("R10 error set", 32'(size_err), 32'd1);
          chk("R10 no read", 32'(req_seen), 32'd0);
          pulse_req();
          repeat (3) @(negedge clk);
          chk("R10 req ignored", 32'(req_seen), 32'd0);
          chk("R10 error sticky", 32'(size_err), 32'd1);
        end else begin
          model_fetch(flows[fi], 4'(sz));
          wait_done("R4 R5 sweep");
          verify_all("sweep");
          if (sz == 2) begin
            // R9 chained fetch from stored configuration
            accepted = 0;
            model_fetch(flows[fi], 4'(sz));
            pulse_req();
            wait_done("R9 chain");
            verify_all("R9 chain");
          end
        end
      end
    end

    // R11 and R7: writes during a fetch are dropped, cfg frozen
    e_cp = 32'h0055_0000;
    sw_write(2'd1, e_cp);
    cw = {1'b0, 3'd4, 4'd9, 8'h00};
    accepted = 0;
    sw_write(2'd2, {16'h0, cw});
    e_cfg = cw;
    model_fetch(3'd4, 4'd9);
    sw_write(2'd0, 32'hFFFF_FFFF);
    chk("R7 cfg mid-fetch", 32'(cfg_word), 32'(cw));
    chk("R11 busy during write", 32'(busy), 32'd1);
    wait_done("R11");
    verify_all("R11");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule